// File: doc/BRIEF.md
# Segment Descriptor Cache and Address Translation

This block keeps six segment selector registers. Each selector has a hidden descriptor entry beside it that holds a 32-bit base, a 32-bit limit and a writable attribute. Software writes a selector through a write port, and the hidden entry follows that write automatically. A mode input chooses how the entry is filled. In real mode the base is taken straight from the selector and the limit is fixed. In protected mode the block asks an external agent for the descriptor named by the selector, and it fills the entry when the answer comes back.

Every memory access presents a segment index, an offset and a read/write flag. One cycle later the block returns either a linear address (base plus offset, wrapping at 2^32) with a valid strobe, or a fault strobe. An access to a segment whose descriptor fetch is still outstanding is held off with a same-cycle busy flag.

Top module: `seg_xlate`

## Requirements
- R1: After reset every selector is 0, every base is 0, every limit is 0xFFFF, every segment is writable and no fetch is pending, so fetchReq is low.
- R2: A selector write while protMode is 0 sets that segment's base to the selector shifted left by four bits, its limit to 0xFFFF and its attribute to writable, and it raises no fetch.
- R3: A selector write while protMode is 1 marks that segment pending. While any segment is pending, fetchReq is high, fetchIdx names the lowest-numbered pending segment and fetchSel carries that segment's selector. fetchReq stays high until a response arrives.
- R4: When fetchRspValid is high together with fetchReq, the segment on fetchIdx takes its base, limit and writable attribute from the response and stops being pending.
- R5: An access to a pending segment raises busy in the same cycle. It produces neither linValid nor fault in the next cycle.
- R6: An accepted access that passes its checks gives linValid high for exactly the next cycle, with linAddr equal to base + offset modulo 2^32.
- R7: An accepted access is refused, with fault high for the next cycle and linValid low, if its offset is above the limit or if its segment index is 6 or 7. Offset equal to the limit is allowed.
- R8: An accepted write access to a segment whose attribute is not writable faults. A read access to the same segment is allowed.
- R9: If a selector write and a fetch response hit the same segment in the same cycle, the write takes priority. A protected-mode write leaves the segment pending. A real-mode write installs the real-mode values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protMode | input | 1 | 1 selects protected-mode loading, 0 selects real-mode loading |
| selWrValid | input | 1 | Selector write strobe |
| selWrIdx | input | 3 | Segment to write |
| selWrValue | input | 16 | New selector value |
| fetchReq | output | 1 | A descriptor fetch is outstanding |
| fetchIdx | output | 3 | Segment that the outstanding fetch serves |
| fetchSel | output | 16 | Selector of that segment |
| fetchRspValid | input | 1 | Descriptor response strobe |
| fetchRspBase | input | 32 | Base from the descriptor |
| fetchRspLimit | input | 32 | Limit from the descriptor |
| fetchRspWritable | input | 1 | 1 if the segment accepts writes |
| accValid | input | 1 | Access request strobe |
| accIdx | input | 3 | Segment used by the access |
| accOffset | input | 32 | Offset within the segment |
| accWrite | input | 1 | 1 for a write access, 0 for a read |
| busy | output | 1 | Access is held off by a pending fetch |
| linValid | output | 1 | linAddr is valid this cycle |
| linAddr | output | 32 | Translated linear address |
| fault | output | 1 | The access of the previous cycle was refused |

## Verification
The bench builds the block with its default parameters: six segments, 16-bit selectors and 32-bit addresses. At these sizes the 3-bit index can name two segments that do not exist, so the out-of-range fault is reachable. Random limits run from zero, a one-byte segment, up to 0xFFFFFFFF, so the equal-to-limit and limit-plus-one offsets and the address wrap past 2^32 all occur. The random stimulus mixes modes on each write, so several segments are often pending at once. That exercises lowest-index service order and the same-cycle write-versus-response collisions.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic selLoad;   // capture a new selector value
    logic realLoad;  // install real-mode base/limit/attribute
    logic fillLoad;  // install fetched descriptor on fetchIdx
    logic emit;      // register a translated linear address
  } segStrobe_t;
endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             protMode,
  input  logic             selWrValid,
  input  logic [IDX_W-1:0] selWrIdx,
  input  logic             fetchRspValid,
  input  logic             accValid,
  input  logic [IDX_W-1:0] accIdx,
  input  logic             accWrite,
  input  logic             overLimit,
  input  logic             segWritable,
  output segStrobe_t       strobe,
  output logic             fetchReq,
  output logic [IDX_W-1:0] fetchIdx,
  output logic             busy,
  output logic             linValid,
  output logic             fault
);
  logic [NUM_SEG-1:0] pending;
  logic               idxOk, wrIdxOk, accGo, accBad;

  assign idxOk   = {1'b0, accIdx} < (IDX_W+1)'(NUM_SEG);
  assign wrIdxOk = {1'b0, selWrIdx} < (IDX_W+1)'(NUM_SEG);

  // lowest-numbered pending segment is served first
  always_comb begin
    fetchIdx = '0;
    for (int i = NUM_SEG - 1; i >= 0; i--)
      if (pending[i]) fetchIdx = IDX_W'(i);
  end

  assign fetchReq = |pending;
  assign busy     = accValid && idxOk && pending[accIdx];
  assign accGo    = accValid && !busy;
  assign accBad   = !idxOk || overLimit || (accWrite && !segWritable);

  always_comb begin
    strobe          = '0;
    strobe.selLoad  = selWrValid && wrIdxOk;
    strobe.realLoad = selWrValid && wrIdxOk && !protMode;
    strobe.fillLoad = fetchRspValid && fetchReq;
    strobe.emit     = accGo && !accBad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= '0;
      linValid <= 1'b0;
      fault    <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_SEG; i++) begin
        if (strobe.selLoad && selWrIdx == IDX_W'(i))
          pending[i] <= protMode;           // write wins over a same-cycle fill
        else if (strobe.fillLoad && fetchIdx == IDX_W'(i))
          pending[i] <= 1'b0;
      end
      linValid <= accGo && !accBad;
      fault    <= accGo && accBad;
    end
  end
endmodule

// File: rtl/seg_xlate_data.sv
module seg_xlate_data
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEL_W = 16,
  parameter int ADDR_W = 32,
  parameter int REAL_SHIFT = 4,
  parameter logic [ADDR_W-1:0] REAL_LIMIT = 'hFFFF,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobe_t        strobe,
  input  logic [IDX_W-1:0]  selWrIdx,
  input  logic [SEL_W-1:0]  selWrValue,
  input  logic [IDX_W-1:0]  fetchIdx,
  input  logic [ADDR_W-1:0] fetchRspBase,
  input  logic [ADDR_W-1:0] fetchRspLimit,
  input  logic              fetchRspWritable,
  input  logic [IDX_W-1:0]  accIdx,
  input  logic [ADDR_W-1:0] accOffset,
  output logic [SEL_W-1:0]  fetchSel,
  output logic              overLimit,
  output logic              segWritable,
  output logic [ADDR_W-1:0] linAddr
);
  logic [SEL_W-1:0]  selReg   [NUM_SEG];
  logic [ADDR_W-1:0] baseReg  [NUM_SEG];
  logic [ADDR_W-1:0] limitReg [NUM_SEG];
  logic [NUM_SEG-1:0] wrOkReg;
  logic               idxOk;
  logic [ADDR_W-1:0]  realBase;

  assign idxOk       = {1'b0, accIdx} < (IDX_W+1)'(NUM_SEG);
  assign realBase    = ADDR_W'(selWrValue) << REAL_SHIFT;
  assign fetchSel    = selReg[fetchIdx];
  assign overLimit   = idxOk && (accOffset > limitReg[accIdx]);
  assign segWritable = idxOk && wrOkReg[accIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        selReg[i]   <= '0;
        baseReg[i]  <= '0;
        limitReg[i] <= REAL_LIMIT;
        wrOkReg[i]  <= 1'b1;
      end
      linAddr <= '0;
    end else begin
      for (int i = 0; i < NUM_SEG; i++) begin
        if (strobe.selLoad && selWrIdx == IDX_W'(i))
          selReg[i] <= selWrValue;
        if (strobe.realLoad && selWrIdx == IDX_W'(i)) begin
          baseReg[i]  <= realBase;
          limitReg[i] <= REAL_LIMIT;
          wrOkReg[i]  <= 1'b1;
        end else if (strobe.fillLoad && fetchIdx == IDX_W'(i)) begin
          baseReg[i]  <= fetchRspBase;
          limitReg[i] <= fetchRspLimit;
          wrOkReg[i]  <= fetchRspWritable;
        end
      end
      if (strobe.emit) linAddr <= baseReg[accIdx] + accOffset;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEL_W = 16,
  parameter int ADDR_W = 32,
  parameter int REAL_SHIFT = 4,
  parameter logic [ADDR_W-1:0] REAL_LIMIT = 'hFFFF,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protMode,
  input  logic              selWrValid,
  input  logic [IDX_W-1:0]  selWrIdx,
  input  logic [SEL_W-1:0]  selWrValue,
  output logic              fetchReq,
  output logic [IDX_W-1:0]  fetchIdx,
  output logic [SEL_W-1:0]  fetchSel,
  input  logic              fetchRspValid,
  input  logic [ADDR_W-1:0] fetchRspBase,
  input  logic [ADDR_W-1:0] fetchRspLimit,
  input  logic              fetchRspWritable,
  input  logic              accValid,
  input  logic [IDX_W-1:0]  accIdx,
  input  logic [ADDR_W-1:0] accOffset,
  input  logic              accWrite,
  output logic              busy,
  output logic              linValid,
  output logic [ADDR_W-1:0] linAddr,
  output logic              fault
);
  segStrobe_t strobe;
  logic       overLimit, segWritable;

  seg_xlate_ctrl #(.NUM_SEG(NUM_SEG)) u_ctrl (
    .clk(clk), .rstN(rstN), .protMode(protMode),
    .selWrValid(selWrValid), .selWrIdx(selWrIdx),
    .fetchRspValid(fetchRspValid),
    .accValid(accValid), .accIdx(accIdx), .accWrite(accWrite),
    .overLimit(overLimit), .segWritable(segWritable),
    .strobe(strobe), .fetchReq(fetchReq), .fetchIdx(fetchIdx),
    .busy(busy), .linValid(linValid), .fault(fault)
  );

  seg_xlate_data #(
    .NUM_SEG(NUM_SEG), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
    .REAL_SHIFT(REAL_SHIFT), .REAL_LIMIT(REAL_LIMIT)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .selWrIdx(selWrIdx), .selWrValue(selWrValue),
    .fetchIdx(fetchIdx), .fetchRspBase(fetchRspBase),
    .fetchRspLimit(fetchRspLimit), .fetchRspWritable(fetchRspWritable),
    .accIdx(accIdx), .accOffset(accOffset),
    .fetchSel(fetchSel), .overLimit(overLimit),
    .segWritable(segWritable), .linAddr(linAddr)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int NUM_SEG = 6,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input logic             clk,
  input logic             rstN,
  input logic             protMode,
  input logic             selWrValid,
  input logic [IDX_W-1:0] selWrIdx,
  input logic             fetchReq,
  input logic             fetchRspValid,
  input logic             accValid,
  input logic             busy,
  input logic             linValid,
  input logic             fault
);
  assert_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(linValid && fault));

  assert_busy_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!linValid && !fault));

  assert_result_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    (linValid || fault) |-> $past(accValid));

  assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchRspValid && protMode) |=> fetchReq);

  assert_prot_write_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    (selWrValid && protMode && ({1'b0, selWrIdx} < (IDX_W+1)'(NUM_SEG))) |=> fetchReq);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> !fetchReq);
endmodule

bind seg_xlate seg_xlate_chk #(.NUM_SEG(NUM_SEG)) u_chk (.*);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  localparam int NS = 6;

  logic        clk = 1'b0;
  logic        rstN;
  logic        protMode, selWrValid, fetchRspValid, fetchRspWritable;
  logic        accValid, accWrite;
  logic [2:0]  selWrIdx, accIdx;
  logic [15:0] selWrValue;
  logic [31:0] fetchRspBase, fetchRspLimit, accOffset;
  logic        fetchReq, busy, linValid, fault;
  logic [2:0]  fetchIdx;
  logic [15:0] fetchSel;
  logic [31:0] linAddr;

  always #10 clk = ~clk;

  seg_xlate i_seg_xlate (
    .clk(clk), .rstN(rstN), .protMode(protMode),
    .selWrValid(selWrValid), .selWrIdx(selWrIdx), .selWrValue(selWrValue),
    .fetchReq(fetchReq), .fetchIdx(fetchIdx), .fetchSel(fetchSel),
    .fetchRspValid(fetchRspValid), .fetchRspBase(fetchRspBase),
    .fetchRspLimit(fetchRspLimit), .fetchRspWritable(fetchRspWritable),
    .accValid(accValid), .accIdx(accIdx), .accOffset(accOffset),
    .accWrite(accWrite), .busy(busy), .linValid(linValid),
    .linAddr(linAddr), .fault(fault)
  );

  // reference model
  logic [15:0] mSel [NS];
  logic [31:0] mBase [NS], mLim [NS];
  bit          mWr [NS], mPend [NS];
  bit          eLin, eFault;
  logic [31:0] eAddr;
  string       eTag;
  int          checks, fails;

  // stimulus for the next step
  bit          dPm, dSw, dRv, dRw, dAv, dAw;
  int          dSi, dAi;
  logic [15:0] dSv;
  logic [31:0] dRb, dRl, dAo;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit anyPend();
    for (int i = 0; i < NS; i++) if (mPend[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int lowPend();
    for (int i = 0; i < NS; i++) if (mPend[i]) return i;
    return 0;
  endfunction

  task automatic idle();
    dPm = 0; dSw = 0; dRv = 0; dRw = 0; dAv = 0; dAw = 0;
    dSi = 0; dAi = 0; dSv = '0; dRb = '0; dRl = '0; dAo = '0;
  endtask

  task automatic step(string tag);
    bit expBusy, go, bad, ro, over, badIdx;
    int k;
    @(negedge clk);
    chk({eTag, " linValid"}, 32'(linValid), 32'(eLin));
    chk({eTag, " fault"}, 32'(fault), 32'(eFault));
    if (eLin) chk({eTag, " linAddr"}, linAddr, eAddr);
    protMode = dPm; selWrValid = dSw; selWrIdx = 3'(dSi); selWrValue = dSv;
    fetchRspValid = dRv && anyPend();
    fetchRspBase = dRb; fetchRspLimit = dRl; fetchRspWritable = dRw;
    accValid = dAv; accIdx = 3'(dAi); accOffset = dAo; accWrite = dAw;
    #1;
    chk({(tag != "") ? tag : "R3", " fetchReq"}, 32'(fetchReq), 32'(anyPend()));
    if (anyPend()) begin
      chk("R3 fetchIdx", 32'(fetchIdx), 32'(lowPend()));
      chk("R3 fetchSel", 32'(fetchSel), 32'(mSel[lowPend()]));
    end
    badIdx  = dAi >= NS;
    expBusy = dAv && !badIdx && mPend[dAi];
    chk({(tag != "") ? tag : "R5", " busy"}, 32'(busy), 32'(expBusy));
    go   = dAv && !expBusy;
    over = !badIdx && (dAo > mLim[dAi]);
    ro   = !badIdx && dAw && !mWr[dAi];
    bad  = badIdx || over || ro;
    eLin   = go && !bad;
    eFault = go && bad;
    eAddr  = badIdx ? 32'h0 : mBase[dAi] + dAo;
    if (tag != "") eTag = tag;
    else if (expBusy) eTag = "R5";
    else if (badIdx || over) eTag = "R7";
    else if (ro) eTag = "R8";
    else eTag = "R6";
    // model update: response first, then the write overrides it
    if (fetchRspValid) begin
      k = lowPend();
      mBase[k] = dRb; mLim[k] = dRl; mWr[k] = dRw; mPend[k] = 0;
    end
    if (dSw) begin
      mSel[dSi] = dSv;
      if (dPm) mPend[dSi] = 1;
      else begin
        mBase[dSi] = 32'(dSv) << 4; mLim[dSi] = 32'hFFFF;
        mWr[dSi] = 1; mPend[dSi] = 0;
      end
    end
  endtask

  task automatic access(int idx, logic [31:0] off, bit wr, string tag);
    idle(); dAv = 1; dAi = idx; dAo = off; dAw = wr;
    step(tag);
  endtask

  function automatic logic [31:0] randLimit();
    case ($urandom % 4)
      0: return 32'hFFFFFFFF;
      1: return 32'h0;
      default: return (32'h1 << ($urandom % 20)) - 1;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    checks = 0; fails = 0;
    for (int i = 0; i < NS; i++) begin
      mSel[i] = '0; mBase[i] = '0; mLim[i] = 32'hFFFF; mWr[i] = 1; mPend[i] = 0;
    end
    eLin = 0; eFault = 0; eAddr = '0; eTag = "R1";
    idle();
    rstN = 0; protMode = 0; selWrValid = 0; selWrIdx = '0; selWrValue = '0;
    fetchRspValid = 0; fetchRspBase = '0; fetchRspLimit = '0; fetchRspWritable = 0;
    accValid = 0; accIdx = '0; accOffset = '0; accWrite = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1: reset contents
    idle(); step("R1");
    for (int i = 0; i < NS; i++) access(i, 32'hFFFF, 1, "R1");
    access(0, 32'h10000, 0, "R1");

    // R2: real-mode load
    idle(); dSw = 1; dSi = 2; dSv = 16'h1234; step("R2");
    access(2, 32'h10, 1, "R2");
    access(2, 32'h10000, 0, "R2");

    // R3/R5: protected-mode loads, lowest index served first
    idle(); dPm = 1; dSw = 1; dSi = 4; dSv = 16'h0020; step("R3");
    access(4, 32'h0, 0, "R5");
    idle(); dPm = 1; dSw = 1; dSi = 1; dSv = 16'h0038; step("R3");
    idle(); step("R3");
    // R4: fill segment 1 read-only, then segment 4 with full limit
    idle(); dPm = 1; dRv = 1; dRb = 32'h4000_0000; dRl = 32'hFF; dRw = 0; step("R4");
    idle(); dPm = 1; dRv = 1; dRb = 32'hFFFF_FF00; dRl = 32'hFFFF_FFFF; dRw = 1; step("R4");
    access(4, 32'h200, 1, "R6");
    access(1, 32'h0, 1, "R8");
    access(1, 32'hFF, 0, "R4");
    access(1, 32'h100, 0, "R7");
    access(6, 32'h0, 0, "R7");
    access(7, 32'h0, 1, "R7");

    // R9: write and response collide on one segment
    idle(); dPm = 1; dSw = 1; dSi = 3; dSv = 16'h0050; step("R9");
    idle(); dRv = 1; dRb = 32'h1234_0000; dRl = 32'h10; dRw = 0;
    dSw = 1; dSi = 3; dSv = 16'h0001; dPm = 0; step("R9");
    access(3, 32'h5, 1, "R9");
    idle(); dPm = 1; dSw = 1; dSi = 5; dSv = 16'h0060; step("R9");
    idle(); dPm = 1; dRv = 1; dRb = 32'h0; dRl = 32'h0; dRw = 0;
    dSw = 1; dSi = 5; dSv = 16'h0068; step("R9");
    access(5, 32'h0, 0, "R9");
    idle(); dPm = 1; dRv = 1; dRb = 32'h8000; dRl = 32'h0; dRw = 1; step("R4");
    access(5, 32'h0, 1, "R4");
    access(5, 32'h1, 0, "R7");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      idle();
      dPm = ($urandom % 3) != 0;
      dSw = ($urandom % 4) == 0;
      dSi = $urandom % NS;
      dSv = 16'($urandom);
      dRv = ($urandom % 3) == 0;
      dRb = $urandom; dRl = randLimit(); dRw = $urandom % 2;
      dAv = ($urandom % 4) != 0;
      dAi = $urandom % 8;
      if (dAi >= NS && ($urandom % 4) != 0) dAi = $urandom % NS;
      dAw = $urandom % 2;
      if (dAi < NS) begin
        case ($urandom % 4)
          0: dAo = mLim[dAi];
          1: dAo = mLim[dAi] + 1;
          2: dAo = $urandom & 32'h1FFFF;
          default: dAo = $urandom;
        endcase
      end else dAo = $urandom;
      step("");
    end
    idle(); step("");
    idle(); step("");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule